// File: doc/BRIEF.md
# Reset and Strap Latch Sequencer

This block brings a transceiver out of reset in an orderly way. It handles two starting events: the rise of a power-good indication, and the release of an external active-low reset pin. After either event it waits a fixed time, samples the hardware-configuration (strap) pins into a held configuration word, then hands those pins over to their normal functional role, and finally raises a flag that permits management register access. The power-up path uses long waits and the pin-reset path uses short ones. Each path has its own capture instant, pin-release instant and ready instant.

The reset pin is synchronized and then filtered for width. A low pulse shorter than the minimum width is ignored. A low level that lasts long enough aborts whatever phase is in progress, drops the functional enable and the ready flag, and starts the pin-reset timing again once the pin rises. Every duration is given in nanoseconds and converted to clock cycles from a clock-frequency parameter, rounding up to whole cycles.

Top module: `cfg_latch_seq`

## Requirements
- R1: While `powerGood` is low, `cfgWord` is 0 and `pinsFunctional` and `mgmtReady` are 0.
- R2: On the power-up path, `cfgWord` takes the value of `strapPins` sampled at the rising edge that is number PWR_CAP (counted from 1) after `powerGood` goes high. Before that edge it stays 0.
- R3: On the power-up path, `pinsFunctional` rises at edge PWR_CAP + PWR_REL after `powerGood` goes high.
- R4: On the power-up path, `mgmtReady` rises at edge PWR_RDY after `powerGood` goes high.
- R5: A low pulse on `rstPinN` lasting fewer than RST_MIN clock cycles has no effect on any output.
- R6: When `rstPinN` stays low for RST_MIN cycles or more, `pinsFunctional` and `mgmtReady` fall at edge RST_MIN + 2 after the pin goes low. That count is two synchronizer stages plus the width filter.
- R7: After a qualifying reset, let edge 1 be the first edge that sees the pin high. `cfgWord` takes `strapPins` at edge 3 + PIN_CAP.
- R8: After a qualifying reset, `pinsFunctional` rises at edge 3 + PIN_CAP + PIN_REL, counted the same way as in R7.
- R9: After a qualifying reset, `mgmtReady` rises at edge 3 + PIN_RDY, counted the same way as in R7.
- R10: A qualifying reset during any phase (power-up wait, pin-reset wait, or running) restarts the pin-reset timing from the release of the pin. `cfgWord` keeps its previous value until the new capture.
- R11: `cfgWord` changes only at a capture edge. Strap changes at any other time do not alter it.
- R12: Each cycle count equals ceil(ns × CLK_KHZ / 1 000 000), for example 110 ns at 125 000 kHz gives 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| powerGood | input | 1 | Power-good indication; low resets the block asynchronously, and its rise starts the power-up path |
| rstPinN | input | 1 | Raw active-low reset pin, asynchronous |
| strapPins | input | STRAP_W | Levels on the hardware-configuration pins |
| cfgWord | output | STRAP_W | Latched configuration word |
| pinsFunctional | output | 1 | High when the strap pins are handed to their functional role |
| mgmtReady | output | 1 | High when management register access is permitted |

## Verification
Each result has a due edge. For the power-up path the count starts at the first clock edge after `powerGood` rises: the capture is due at edge PWR_CAP, the pin release at PWR_CAP + PWR_REL, and ready at PWR_RDY. For a pin reset, the drop of the functional enable and the ready flag is due at edge RST_MIN + 2 after the pin falls. The capture, release and ready edges are due 3 + PIN_CAP, 3 + PIN_CAP + PIN_REL and 3 + PIN_RDY edges after the pin rises. The bench drives and samples on falling edges and counts edges from each stimulus. It checks every output both on the edge just before its due edge and on the due edge itself, so an off-by-one in either direction is caught. It also uses shortened durations so that every path completes quickly.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [1:0] {
    ST_PWR_SEQ  = 2'd0,
    ST_PIN_HOLD = 2'd1,
    ST_PIN_SEQ  = 2'd2,
    ST_RUN      = 2'd3
  } seqState_t;

  typedef struct packed {
    logic capStb;
    logic relStb;
    logic rdyStb;
    logic abortStb;
  } seqStrobe_t;

  // Round a duration up to whole clock cycles (at least one).
  function automatic longint unsigned nsToCycles(longint unsigned ns,
                                                 longint unsigned khz);
    longint unsigned c;
    c = (ns * khz + 64'd999_999) / 64'd1_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cls_pin_filter.sv
module cls_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_MIN_CYC = 625
) (
  input  logic clk,
  input  logic powerGood,
  input  logic rstPinN,
  output logic pinHigh,
  output logic qualify
);
  localparam int unsigned FW = $clog2(RST_MIN_CYC + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FW-1:0]          lowCnt;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) syncQ <= '1;
    else            syncQ <= {syncQ[SYNC_STAGES-2:0], rstPinN};
  end

  assign pinHigh = syncQ[SYNC_STAGES-1];

  // Saturating low-time counter; qualification fires once per low period.
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                           lowCnt <= '0;
    else if (pinHigh)                         lowCnt <= '0;
    else if (lowCnt != FW'(RST_MIN_CYC))      lowCnt <= lowCnt + FW'(1);
  end

  assign qualify = !pinHigh && (lowCnt == FW'(RST_MIN_CYC - 1));

  // R5: a qualification needs the synchronized pin low in the cycle before
  a_r5_qual_after_low: assert property (@(posedge clk) disable iff (!powerGood)
    qualify |-> ($past(pinHigh) == 1'b0 || RST_MIN_CYC == 1));

endmodule

// File: rtl/cls_ctrl.sv
module cls_ctrl
  import cls_pkg::*;
#(
  parameter int unsigned PWR_CAP_CYC = 8,
  parameter int unsigned PWR_REL_CYC = 2,
  parameter int unsigned PWR_RDY_CYC = 16,
  parameter int unsigned PIN_CAP_CYC = 4,
  parameter int unsigned PIN_REL_CYC = 2,
  parameter int unsigned PIN_RDY_CYC = 12
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       qualify,
  input  logic       pinHigh,
  output seqStrobe_t stb
);
  localparam int unsigned MAX_CYC = maxOf(maxOf(PWR_RDY_CYC, PIN_RDY_CYC),
                                          maxOf(PWR_CAP_CYC + PWR_REL_CYC,
                                                PIN_CAP_CYC + PIN_REL_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] PWR_CAP_AT = CNT_W'(PWR_CAP_CYC - 1);
  localparam logic [CNT_W-1:0] PWR_REL_AT = CNT_W'(PWR_CAP_CYC + PWR_REL_CYC - 1);
  localparam logic [CNT_W-1:0] PWR_RDY_AT = CNT_W'(PWR_RDY_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_CAP_AT = CNT_W'(PIN_CAP_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_REL_AT = CNT_W'(PIN_CAP_CYC + PIN_REL_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_RDY_AT = CNT_W'(PIN_RDY_CYC - 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] capAt, relAt, rdyAt;
  logic             inSeq;

  // Profile selection: one shared counter, targets chosen per path.
  always_comb begin
    inSeq = (state == ST_PWR_SEQ) || (state == ST_PIN_SEQ);
    if (state == ST_PIN_SEQ) begin
      capAt = PIN_CAP_AT;
      relAt = PIN_REL_AT;
      rdyAt = PIN_RDY_AT;
    end else begin
      capAt = PWR_CAP_AT;
      relAt = PWR_REL_AT;
      rdyAt = PWR_RDY_AT;
    end
  end

  always_comb begin
    stb.abortStb = qualify;
    stb.capStb   = inSeq && !qualify && (elapsed == capAt);
    stb.relStb   = inSeq && !qualify && (elapsed == relAt);
    stb.rdyStb   = inSeq && !qualify && (elapsed == rdyAt);
  end

  always_comb begin
    stateNxt = state;
    if (qualify) begin
      stateNxt = ST_PIN_HOLD;
    end else begin
      unique case (state)
        ST_PIN_HOLD: if (pinHigh) stateNxt = ST_PIN_SEQ;
        ST_PWR_SEQ,
        ST_PIN_SEQ:  if (stb.rdyStb) stateNxt = ST_RUN;
        default:     stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      state   <= ST_PWR_SEQ;
      elapsed <= '0;
    end else begin
      state <= stateNxt;
      if (qualify || state == ST_PIN_HOLD) elapsed <= '0;
      else if (inSeq)                      elapsed <= elapsed + CNT_W'(1);
    end
  end

  // R6: a qualified reset always lands in the hold state
  a_r6_qual_to_hold: assert property (@(posedge clk) disable iff (!powerGood)
    qualify |=> (state == ST_PIN_HOLD));

  // R10: nothing is captured, released or readied while the pin is held
  a_r10_quiet_in_hold: assert property (@(posedge clk) disable iff (!powerGood)
    (state == ST_PIN_HOLD) |-> !(stb.capStb || stb.relStb || stb.rdyStb));

  // R9: the running state is reached only through a ready strobe
  a_r9_run_via_ready: assert property (@(posedge clk) disable iff (!powerGood)
    (state != ST_RUN) ##1 (state == ST_RUN) |-> $past(stb.rdyStb));

endmodule

// File: rtl/cls_datapath.sv
module cls_datapath
  import cls_pkg::*;
#(
  parameter int unsigned STRAP_W = 6
) (
  input  logic               clk,
  input  logic               powerGood,
  input  seqStrobe_t         stb,
  input  logic [STRAP_W-1:0] strapPins,
  output logic [STRAP_W-1:0] cfgWord,
  output logic               pinsFunctional,
  output logic               mgmtReady
);

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)      cfgWord <= '0;
    else if (stb.capStb) cfgWord <= strapPins;
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      pinsFunctional <= 1'b0;
      mgmtReady      <= 1'b0;
    end else if (stb.abortStb) begin
      pinsFunctional <= 1'b0;
      mgmtReady      <= 1'b0;
    end else begin
      if (stb.relStb) pinsFunctional <= 1'b1;
      if (stb.rdyStb) mgmtReady      <= 1'b1;
    end
  end

  // R6: an abort drops both flags on the next cycle
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!powerGood)
    stb.abortStb |=> (!mgmtReady && !pinsFunctional));

  // R11: the configuration word moves only on a capture
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!powerGood)
    !stb.capStb |=> $stable(cfgWord));

  // R4 / R9: ready is never granted while the pins are still in strap mode
  a_r9_ready_needs_func: assert property (@(posedge clk) disable iff (!powerGood)
    mgmtReady |-> pinsFunctional);

endmodule

// File: rtl/cfg_latch_seq.sv
module cfg_latch_seq
  import cls_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 125_000,
  parameter int unsigned STRAP_W     = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_MIN_NS  = 5_000,
  parameter int unsigned PIN_CAP_NS  = 2_000,
  parameter int unsigned PIN_REL_NS  = 1_500,
  parameter int unsigned PIN_RDY_NS  = 1_000_000,
  parameter int unsigned PWR_CAP_NS  = 60_000_000,
  parameter int unsigned PWR_REL_NS  = 110,
  parameter int unsigned PWR_RDY_NS  = 65_000_000
) (
  input  logic               clk,
  input  logic               powerGood,
  input  logic               rstPinN,
  input  logic [STRAP_W-1:0] strapPins,
  output logic [STRAP_W-1:0] cfgWord,
  output logic               pinsFunctional,
  output logic               mgmtReady
);
  // R12: every duration rounded up to whole cycles
  localparam int unsigned RST_MIN_CYC = 32'(nsToCycles(RST_MIN_NS, CLK_KHZ));
  localparam int unsigned PIN_CAP_CYC = 32'(nsToCycles(PIN_CAP_NS, CLK_KHZ));
  localparam int unsigned PIN_REL_CYC = 32'(nsToCycles(PIN_REL_NS, CLK_KHZ));
  localparam int unsigned PIN_RDY_CYC = 32'(nsToCycles(PIN_RDY_NS, CLK_KHZ));
  localparam int unsigned PWR_CAP_CYC = 32'(nsToCycles(PWR_CAP_NS, CLK_KHZ));
  localparam int unsigned PWR_REL_CYC = 32'(nsToCycles(PWR_REL_NS, CLK_KHZ));
  localparam int unsigned PWR_RDY_CYC = 32'(nsToCycles(PWR_RDY_NS, CLK_KHZ));

  logic       pinHigh;
  logic       qualify;
  seqStrobe_t stb;

  cls_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .RST_MIN_CYC (RST_MIN_CYC)
  ) u_filter (
    .clk       (clk),
    .powerGood (powerGood),
    .rstPinN   (rstPinN),
    .pinHigh   (pinHigh),
    .qualify   (qualify)
  );

  cls_ctrl #(
    .PWR_CAP_CYC (PWR_CAP_CYC),
    .PWR_REL_CYC (PWR_REL_CYC),
    .PWR_RDY_CYC (PWR_RDY_CYC),
    .PIN_CAP_CYC (PIN_CAP_CYC),
    .PIN_REL_CYC (PIN_REL_CYC),
    .PIN_RDY_CYC (PIN_RDY_CYC)
  ) u_ctrl (
    .clk       (clk),
    .powerGood (powerGood),
    .qualify   (qualify),
    .pinHigh   (pinHigh),
    .stb       (stb)
  );

  cls_datapath #(
    .STRAP_W (STRAP_W)
  ) u_dp (
    .clk            (clk),
    .powerGood      (powerGood),
    .stb            (stb),
    .strapPins      (strapPins),
    .cfgWord        (cfgWord),
    .pinsFunctional (pinsFunctional),
    .mgmtReady      (mgmtReady)
  );

endmodule

// File: tb/cfg_latch_seq_tb.sv
module cfg_latch_seq_tb;
  localparam int unsigned KHZ        = 125_000;
  localparam int unsigned SW         = 6;
  localparam int unsigned RST_MIN_NS = 400;
  localparam int unsigned PIN_CAP_NS = 200;
  localparam int unsigned PIN_REL_NS = 120;
  localparam int unsigned PIN_RDY_NS = 16_000;
  localparam int unsigned PWR_CAP_NS = 40_000;
  localparam int unsigned PWR_REL_NS = 110;
  localparam int unsigned PWR_RDY_NS = 48_000;

  function automatic int unsigned cyc(int unsigned ns);
    longint unsigned p;
    p = longint'(ns) * longint'(KHZ);
    return 32'((p + 64'd999_999) / 64'd1_000_000);
  endfunction

  localparam int MIN_C  = int'(cyc(RST_MIN_NS));
  localparam int PIN_C  = int'(cyc(PIN_CAP_NS));
  localparam int PIN_L  = int'(cyc(PIN_REL_NS));
  localparam int PIN_Y  = int'(cyc(PIN_RDY_NS));
  localparam int PWR_C  = int'(cyc(PWR_CAP_NS));
  localparam int PWR_L  = int'(cyc(PWR_REL_NS));
  localparam int PWR_Y  = int'(cyc(PWR_RDY_NS));

  logic          clk = 1'b0;
  logic          powerGood = 1'b0;
  logic          rstPinN = 1'b1;
  logic [SW-1:0] strapPins = '0;
  logic [SW-1:0] cfgWord;
  logic          pinsFunctional;
  logic          mgmtReady;

  int checks = 0;
  int errors = 0;
  logic [SW-1:0] cfgExp = '0;

  always #4 clk = ~clk;

  cfg_latch_seq #(
    .CLK_KHZ (KHZ), .STRAP_W (SW), .SYNC_STAGES (2),
    .RST_MIN_NS (RST_MIN_NS), .PIN_CAP_NS (PIN_CAP_NS), .PIN_REL_NS (PIN_REL_NS),
    .PIN_RDY_NS (PIN_RDY_NS), .PWR_CAP_NS (PWR_CAP_NS), .PWR_REL_NS (PWR_REL_NS),
    .PWR_RDY_NS (PWR_RDY_NS)
  ) u_dut (
    .clk (clk), .powerGood (powerGood), .rstPinN (rstPinN), .strapPins (strapPins),
    .cfgWord (cfgWord), .pinsFunctional (pinsFunctional), .mgmtReady (mgmtReady)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] rndStrap();
    return SW'($urandom);
  endfunction

  // Full power-up run with checks on both sides of every due edge.
  task automatic powerUpFull(logic [SW-1:0] s);
    powerGood = 1'b0;
    tick(3);
    chk("R1", "cfgWord in reset", int'(cfgWord), 0);
    chk("R1", "pinsFunctional in reset", int'(pinsFunctional), 0);
    chk("R1", "mgmtReady in reset", int'(mgmtReady), 0);
    strapPins = s;
    powerGood = 1'b1;
    tick(PWR_C - 1);
    chk("R2", "cfgWord before capture", int'(cfgWord), 0);
    tick(1);
    chk("R2", "cfgWord at capture", int'(cfgWord), int'(s));
    strapPins = ~s;
    tick(PWR_L - 1);
    chk("R3_R12", "pinsFunctional before release", int'(pinsFunctional), 0);
    tick(1);
    chk("R3_R12", "pinsFunctional at release", int'(pinsFunctional), 1);
    tick(PWR_Y - PWR_C - PWR_L - 1);
    chk("R4", "mgmtReady before due", int'(mgmtReady), 0);
    tick(1);
    chk("R4", "mgmtReady at due", int'(mgmtReady), 1);
    chk("R11", "cfgWord after strap change", int'(cfgWord), int'(s));
    cfgExp = s;
  endtask

  // Qualifying pin reset of L cycles; checks drop, capture, release, ready.
  task automatic runPin(int L, logic [SW-1:0] s);
    logic [SW-1:0] old;
    old = cfgExp;
    strapPins = s;
    rstPinN = 1'b0;
    for (int k = 1; k <= L + 3 + PIN_Y; k++) begin
      tick(1);
      if (k == L) rstPinN = 1'b1;
      if (k == MIN_C + 2) begin
        chk("R6", "mgmtReady after qualify", int'(mgmtReady), 0);
        chk("R6", "pinsFunctional after qualify", int'(pinsFunctional), 0);
      end
      if (k == L + 2 + PIN_C)
        chk("R10", "cfgWord held until capture", int'(cfgWord), int'(old));
      if (k == L + 3 + PIN_C) begin
        chk("R7", "cfgWord at pin capture", int'(cfgWord), int'(s));
        strapPins = rndStrap();
      end
      if (k == L + 2 + PIN_C + PIN_L)
        chk("R8", "pinsFunctional before release", int'(pinsFunctional), 0);
      if (k == L + 3 + PIN_C + PIN_L)
        chk("R8", "pinsFunctional at release", int'(pinsFunctional), 1);
      if (k == L + 2 + PIN_Y)
        chk("R9", "mgmtReady before due", int'(mgmtReady), 0);
      if (k == L + 3 + PIN_Y)
        chk("R9", "mgmtReady at due", int'(mgmtReady), 1);
    end
    chk("R11", "cfgWord after strap change", int'(cfgWord), int'(s));
    cfgExp = s;
  endtask

  // Sub-threshold pulse while running: nothing may change.
  task automatic shortPulse(int L);
    rstPinN = 1'b0;
    strapPins = rndStrap();
    tick(L);
    rstPinN = 1'b1;
    tick(MIN_C + 6);
    chk("R5", "mgmtReady after short pulse", int'(mgmtReady), 1);
    chk("R5", "pinsFunctional after short pulse", int'(pinsFunctional), 1);
    chk("R5", "cfgWord after short pulse", int'(cfgWord), int'(cfgExp));
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [SW-1:0] s1;
    void'($urandom(32'd20240611));
    chk("R12", "power release cycles", PWR_L, 14);

    powerUpFull(6'h2d);

    shortPulse(MIN_C - 1);
    shortPulse(1);
    for (int i = 0; i < 12; i++) shortPulse(1 + int'($urandom % 32'(MIN_C - 1)));

    runPin(MIN_C, 6'h15);
    runPin(MIN_C + 7, 6'h3a);
    for (int i = 0; i < 4; i++) begin
      runPin(MIN_C + int'($urandom % 32'd40), rndStrap());
      shortPulse(1 + int'($urandom % 32'(MIN_C - 1)));
    end

    // R10: abort during the power-up capture wait; word stays 0 until capture
    powerGood = 1'b0;
    tick(2);
    powerGood = 1'b1;
    tick(100);
    cfgExp = '0;
    chk("R10", "cfgWord during power wait", int'(cfgWord), 0);
    runPin(MIN_C + 3, 6'h0f);

    // R10: abort after power-up capture and release, before ready
    powerGood = 1'b0;
    tick(2);
    strapPins = 6'h21;
    powerGood = 1'b1;
    tick(PWR_C + PWR_L + 10);
    chk("R3", "pinsFunctional mid power path", int'(pinsFunctional), 1);
    chk("R4", "mgmtReady mid power path", int'(mgmtReady), 0);
    cfgExp = 6'h21;
    runPin(MIN_C + 2, 6'h1e);

    // R10: abort in the middle of a pin-reset sequence
    s1 = 6'h33;
    strapPins = s1;
    rstPinN = 1'b0;
    tick(MIN_C + 3);
    rstPinN = 1'b1;
    tick(3 + PIN_C + PIN_L + 5);
    chk("R8", "pinsFunctional mid pin path", int'(pinsFunctional), 1);
    chk("R9", "mgmtReady mid pin path", int'(mgmtReady), 0);
    chk("R7", "cfgWord mid pin path", int'(cfgWord), int'(s1));
    cfgExp = s1;
    runPin(MIN_C + 1, 6'h0c);
    shortPulse(MIN_C - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule